// File: doc/BRIEF.md
# Squash Walker for a Multi-Thread Reorder Queue

This block removes the younger instructions of one thread from a reorder queue after a misprediction or exception in that thread. A request names the thread and a boundary sequence number. Every entry of that thread whose sequence number is above the boundary must be killed.

The walker does not delete those entries. It walks the thread's ring slice backwards, starting at the youngest entry and moving towards the oldest. It touches at most a fixed number of entries per clock. For each entry it passes, it raises a "squashed" mark and a "may commit" mark, so the queue's storage flags the entry and the entry later leaves through ordinary retirement.

Each thread has a completion flag. The flag drops when that thread's walk is accepted and rises again once the walk is over. A separate pulse tells the surrounding logic to recompute the global youngest pointer whenever the thread's youngest entry is killed.

The queue owns the storage. It supplies every entry's sequence number and, for each thread, the slot of its oldest entry (head), the slot of its youngest entry (tail) and its occupancy. Slots within a thread wrap modulo DEPTH. Sequence numbers compare as unsigned values.

Top module: `squash_walker`

## Requirements
- R1: While reset is asserted and after it, every bit of `thr_done` is 1, and `mark_squash`, `mark_commit` and `tail_recalc` are 0 until a request is accepted.
- R2: A request is ignored when the occupancy of every thread is zero. No done flag changes and no mark appears.
- R3: An accepted request clears `thr_done[sq_tid]` at the next clock. The walk marks its first entries in the cycle after acceptance, starting at the thread's tail slot.
- R4: In any cycle, marks appear for one thread only and for at most WIDTH entries. The marked entries are consecutive slots going downward from the walk position, with the slot index wrapping from 0 to DEPTH-1. The next cycle continues directly below the last marked slot.
- R5: An entry is marked only if its sequence number is strictly greater than the boundary. The first entry at or below the boundary ends the walk, and neither it nor any older entry is marked.
- R6: `mark_commit` equals `mark_squash` bit for bit in every cycle.
- R7: Marking the thread's head slot ends the walk, even when entries in other slots hold larger numbers.
- R8: `thr_done` of the walking thread rises at the clock that ends the walk cycle in which the walk stopped. This includes the case where the width limit is used up and the next slot already holds a number at or below the boundary.
- R9: `tail_recalc` is 1 exactly in the cycles in which the walking thread's tail slot is marked.
- R10: Only one walk runs at a time, and an accepted request replaces the running walk. If the request is for the same thread, that thread's done flag stays 0. If it is for another thread, the abandoned thread's done flag is set at the same clock.
- R11: A request for a thread with zero occupancy is accepted while another thread holds entries. That walk marks nothing and raises the thread's done flag after one walk cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sq_req | input | 1 | Squash request strobe |
| sq_tid | input | TID_W | Thread of the request |
| sq_seq | input | SEQ_W | Boundary; entries above it are killed |
| ent_seq | input | THREADS*DEPTH*SEQ_W | Sequence number of every slot, thread-major |
| thr_head | input | THREADS*IDX_W | Oldest slot per thread |
| thr_tail | input | THREADS*IDX_W | Youngest slot per thread |
| thr_cnt | input | THREADS*CNT_W | Occupancy per thread |
| mark_squash | output | THREADS*DEPTH | Per-slot squashed mark, one cycle |
| mark_commit | output | THREADS*DEPTH | Per-slot may-commit mark, one cycle |
| thr_done | output | THREADS | Per-thread walk complete |
| tail_recalc | output | 1 | Request to recompute the global tail |

## Verification
The bench uses two threads, eight slots per thread, 8-bit sequence numbers and a width of three.

Because three does not divide eight, walks end partway through a group, both at the boundary and at the head. A full thread whose head sits at slot 6 forces the walk position to wrap past slot 0.

With two threads, the bench can exercise preemption by another thread's request, restart of the same thread, and a request for an empty thread while the other thread is occupied.

// File: rtl/squash_walker_pkg.sv
package squash_walker_pkg;
  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_phase_e;
endpackage

// File: rtl/sqw_window.sv
// Combinational examination of up to WIDTH slots below the walk position.
module sqw_window #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8,
  parameter int WIDTH = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [IDX_W-1:0]       ptr,
  input  logic [IDX_W-1:0]       head,
  input  logic [IDX_W-1:0]       tail,
  input  logic [CNT_W-1:0]       cnt,
  input  logic [SEQ_W-1:0]       lim,
  input  logic [DEPTH*SEQ_W-1:0] row,
  output logic [DEPTH-1:0]       hit,
  output logic                   fin,
  output logic                   tail_hit
);
  logic             go;
  logic [IDX_W-1:0] idx;

  always_comb begin
    hit      = '0;
    fin      = 1'b0;
    tail_hit = 1'b0;
    go       = 1'b1;
    idx      = ptr;
    if (cnt == '0) begin
      fin = 1'b1;
      go  = 1'b0;
    end
    for (int k = 0; k < WIDTH; k++) begin
      idx = ptr - IDX_W'(k);
      if (go) begin
        if (row[int'(idx)*SEQ_W +: SEQ_W] > lim) begin
          hit[idx] = 1'b1;
          if (idx == tail) tail_hit = 1'b1;
          if (idx == head) begin
            fin = 1'b1;
            go  = 1'b0;
          end
        end else begin
          fin = 1'b1;
          go  = 1'b0;
        end
      end
    end
    // width used up: peek at the next slot below the group
    if (go) begin
      idx = ptr - IDX_W'(WIDTH);
      if (row[int'(idx)*SEQ_W +: SEQ_W] <= lim) fin = 1'b1;
    end
  end
endmodule

// File: rtl/sqw_walk_ctrl.sv
// Walk context and per-thread completion flags.
module sqw_walk_ctrl
  import squash_walker_pkg::*;
#(
  parameter int THREADS = 2,
  parameter int DEPTH   = 8,
  parameter int SEQ_W   = 8,
  parameter int WIDTH   = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int TID_W = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [TID_W-1:0]   req_tid,
  input  logic [IDX_W-1:0]   req_ptr,
  input  logic [SEQ_W-1:0]   req_lim,
  input  logic               fin,
  output logic               active,
  output logic [TID_W-1:0]   cur_tid,
  output logic [IDX_W-1:0]   ptr,
  output logic [SEQ_W-1:0]   lim,
  output logic [THREADS-1:0] done
);
  walk_phase_e        phase_q, phase_n;
  logic [TID_W-1:0]   tid_q, tid_n;
  logic [IDX_W-1:0]   ptr_q, ptr_n;
  logic [SEQ_W-1:0]   lim_q, lim_n;
  logic [THREADS-1:0] done_q, done_n;
  logic               upd_en;

  assign active  = (phase_q == WALK_RUN);
  assign upd_en  = accept | active;

  always_comb begin
    phase_n = phase_q;
    tid_n   = tid_q;
    ptr_n   = ptr_q;
    lim_n   = lim_q;
    if (accept) begin
      phase_n = WALK_RUN;
      tid_n   = req_tid;
      ptr_n   = req_ptr;
      lim_n   = req_lim;
    end else if (active) begin
      if (fin) phase_n = WALK_IDLE;
      else     ptr_n   = ptr_q - IDX_W'(WIDTH);
    end
  end

  always_comb begin
    for (int t = 0; t < THREADS; t++) begin
      done_n[t] = done_q[t];
      if (active && tid_q == TID_W'(t) && (fin || accept)) done_n[t] = 1'b1;
      if (accept && req_tid == TID_W'(t))                   done_n[t] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= WALK_IDLE;
      tid_q   <= '0;
      ptr_q   <= '0;
      lim_q   <= '0;
      done_q  <= '1;
    end else if (upd_en) begin
      phase_q <= phase_n;
      tid_q   <= tid_n;
      ptr_q   <= ptr_n;
      lim_q   <= lim_n;
      done_q  <= done_n;
    end
  end

  assign cur_tid = tid_q;
  assign ptr     = ptr_q;
  assign lim     = lim_q;
  assign done    = done_q;
endmodule

// File: rtl/squash_walker.sv
module squash_walker #(
  parameter int THREADS = 2,
  parameter int DEPTH   = 8,
  parameter int SEQ_W   = 8,
  parameter int WIDTH   = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int TID_W = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int ROW_W = DEPTH * SEQ_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sq_req,
  input  logic [TID_W-1:0]           sq_tid,
  input  logic [SEQ_W-1:0]           sq_seq,
  input  logic [THREADS*ROW_W-1:0]   ent_seq,
  input  logic [THREADS*IDX_W-1:0]   thr_head,
  input  logic [THREADS*IDX_W-1:0]   thr_tail,
  input  logic [THREADS*CNT_W-1:0]   thr_cnt,
  output logic [THREADS*DEPTH-1:0]   mark_squash,
  output logic [THREADS*DEPTH-1:0]   mark_commit,
  output logic [THREADS-1:0]         thr_done,
  output logic                       tail_recalc
);
  logic             rst_s1, rst_sync_n;
  logic             any_live, accept, active, fin, tail_hit;
  logic [TID_W-1:0] cur_tid;
  logic [IDX_W-1:0] ptr, cur_head, cur_tail, req_ptr;
  logic [CNT_W-1:0] cur_cnt;
  logic [SEQ_W-1:0] lim;
  logic [ROW_W-1:0] cur_row;
  logic [DEPTH-1:0] hit;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  always_comb begin
    any_live = 1'b0;
    for (int t = 0; t < THREADS; t++)
      any_live = any_live | (thr_cnt[t*CNT_W +: CNT_W] != '0);
  end

  assign accept   = sq_req & any_live;
  assign req_ptr  = thr_tail[int'(sq_tid)*IDX_W +: IDX_W];
  assign cur_row  = ent_seq[int'(cur_tid)*ROW_W +: ROW_W];
  assign cur_head = thr_head[int'(cur_tid)*IDX_W +: IDX_W];
  assign cur_tail = thr_tail[int'(cur_tid)*IDX_W +: IDX_W];
  assign cur_cnt  = thr_cnt[int'(cur_tid)*CNT_W +: CNT_W];

  sqw_walk_ctrl #(
    .THREADS(THREADS), .DEPTH(DEPTH), .SEQ_W(SEQ_W), .WIDTH(WIDTH)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .accept  (accept),
    .req_tid (sq_tid),
    .req_ptr (req_ptr),
    .req_lim (sq_seq),
    .fin     (fin),
    .active  (active),
    .cur_tid (cur_tid),
    .ptr     (ptr),
    .lim     (lim),
    .done    (thr_done)
  );

  sqw_window #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .WIDTH(WIDTH)
  ) u_win (
    .ptr      (ptr),
    .head     (cur_head),
    .tail     (cur_tail),
    .cnt      (cur_cnt),
    .lim      (lim),
    .row      (cur_row),
    .hit      (hit),
    .fin      (fin),
    .tail_hit (tail_hit)
  );

  for (genvar t = 0; t < THREADS; t++) begin : g_rows
    assign mark_squash[t*DEPTH +: DEPTH] =
      (active && cur_tid == TID_W'(t)) ? hit : '0;
    assign mark_commit[t*DEPTH +: DEPTH] =
      (active && cur_tid == TID_W'(t)) ? hit : '0;
  end

  assign tail_recalc = active & tail_hit;
endmodule

// File: rtl/squash_walker_chk.sv
module squash_walker_chk #(
  parameter int THREADS = 2,
  parameter int DEPTH   = 8,
  parameter int WIDTH   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sq_req,
  input logic [THREADS*DEPTH-1:0] mark_squash,
  input logic [THREADS*DEPTH-1:0] mark_commit,
  input logic [THREADS-1:0]       thr_done,
  input logic                     tail_recalc
);
  logic [THREADS-1:0] row_any;
  for (genvar t = 0; t < THREADS; t++) begin : g_any
    assign row_any[t] = |mark_squash[t*DEPTH +: DEPTH];
  end

  assert_width_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mark_squash) <= WIDTH);

  assert_single_thread_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_any));

  assert_marks_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mark_squash == mark_commit);

  assert_tail_needs_mark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tail_recalc |-> (mark_squash != '0));

  assert_marks_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (row_any & thr_done) == '0);

  assert_done_falls_on_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sq_req) |-> ((~thr_done & $past(thr_done)) == '0));
endmodule

bind squash_walker squash_walker_chk #(
  .THREADS(THREADS), .DEPTH(DEPTH), .WIDTH(WIDTH)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sq_req      (sq_req),
  .mark_squash (mark_squash),
  .mark_commit (mark_commit),
  .thr_done    (thr_done),
  .tail_recalc (tail_recalc)
);

// File: tb/tb_squash_walker.sv
`timescale 1ns/1ps
module tb_squash_walker;
  localparam int T  = 2;
  localparam int D  = 8;
  localparam int SW = 8;
  localparam int W  = 3;
  localparam int IW = 3;
  localparam int CW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic              rst_n;
  logic              sq_req;
  logic [0:0]        sq_tid;
  logic [SW-1:0]     sq_seq;
  logic [T*D*SW-1:0] ent_seq;
  logic [T*IW-1:0]   thr_head, thr_tail;
  logic [T*CW-1:0]   thr_cnt;
  logic [T*D-1:0]    mark_squash, mark_commit;
  logic [T-1:0]      thr_done;
  logic              tail_recalc;

  squash_walker #(.THREADS(T), .DEPTH(D), .SEQ_W(SW), .WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .sq_req(sq_req), .sq_tid(sq_tid), .sq_seq(sq_seq),
    .ent_seq(ent_seq), .thr_head(thr_head), .thr_tail(thr_tail), .thr_cnt(thr_cnt),
    .mark_squash(mark_squash), .mark_commit(mark_commit), .thr_done(thr_done),
    .tail_recalc(tail_recalc));

  int n_cmp = 0, n_bad = 0;

  // behavioural reference: per-thread age-ordered lists
  int       m_head[T], m_cnt[T];
  bit       m_active, m_fin;
  int       m_tid, m_pos, m_lim, m_adv;
  logic [T-1:0]   m_done;
  logic [T*D-1:0] exp_mark;
  logic           exp_tail;

  function automatic int age_seq(int t, int p);
    return (t == 0) ? 10 + 2*p : 40 + p;
  endfunction

  task automatic load_rob(int h0, int c0, int h1, int c1);
    m_head[0] = h0; m_cnt[0] = c0; m_head[1] = h1; m_cnt[1] = c1;
    ent_seq = '1;
    for (int t = 0; t < T; t++) begin
      thr_head[t*IW +: IW] = IW'(m_head[t]);
      thr_tail[t*IW +: IW] = IW'((m_head[t] + (m_cnt[t] > 0 ? m_cnt[t]-1 : 0)) % D);
      thr_cnt[t*CW +: CW]  = CW'(m_cnt[t]);
      for (int p = 0; p < m_cnt[t]; p++)
        ent_seq[(t*D + (m_head[t]+p)%D)*SW +: SW] = SW'(age_seq(t, p));
    end
  endtask

  task automatic model_eval();
    int p;
    exp_mark = '0; exp_tail = 1'b0; m_fin = 1'b0; m_adv = 0;
    if (m_active) begin
      if (m_cnt[m_tid] == 0) m_fin = 1'b1;
      else begin
        p = m_pos;
        while (!m_fin && m_adv < W) begin
          if (age_seq(m_tid, p) > m_lim) begin
            exp_mark[m_tid*D + (m_head[m_tid]+p)%D] = 1'b1;
            if (p == m_cnt[m_tid]-1) exp_tail = 1'b1;
            m_adv++;
            if (p == 0) m_fin = 1'b1; else p--;
          end else m_fin = 1'b1;
        end
        if (!m_fin && age_seq(m_tid, p) <= m_lim) m_fin = 1'b1;
      end
    end
  endtask

  task automatic model_step(bit req, int tid, int seq);
    bit acc;
    acc = req && (m_cnt[0] + m_cnt[1] != 0);
    if (acc) begin
      if (m_active && m_tid != tid) m_done[m_tid] = 1'b1;
      m_done[tid] = 1'b0;
      m_active = 1'b1; m_tid = tid; m_pos = m_cnt[tid]-1; m_lim = seq;
    end else if (m_active) begin
      if (m_fin) begin m_done[m_tid] = 1'b1; m_active = 1'b0; end
      else m_pos = m_pos - m_adv;
    end
  endtask

  task automatic compare(string tag);
    n_cmp++;
    if (mark_squash !== exp_mark) begin
      n_bad++; $display("FAIL %s/R4 mark_squash act=%h exp=%h", tag, mark_squash, exp_mark);
    end
    n_cmp++;
    if (mark_commit !== exp_mark) begin
      n_bad++; $display("FAIL %s/R6 mark_commit act=%h exp=%h", tag, mark_commit, exp_mark);
    end
    n_cmp++;
    if (thr_done !== m_done) begin
      n_bad++; $display("FAIL %s/R8 thr_done act=%b exp=%b", tag, thr_done, m_done);
    end
    n_cmp++;
    if (tail_recalc !== exp_tail) begin
      n_bad++; $display("FAIL %s/R9 tail_recalc act=%b exp=%b", tag, tail_recalc, exp_tail);
    end
  endtask

  task automatic cyc(bit req, int tid, int seq, string tag);
    sq_req = req; sq_tid = 1'(tid); sq_seq = SW'(seq);
    #1;
    model_eval();
    compare(tag);
    model_step(req, tid, seq);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sq_req = 1'b0; sq_tid = '0; sq_seq = '0;
    m_active = 1'b0; m_done = '1; m_tid = 0; m_pos = 0; m_lim = 0;
    load_rob(6, 8, 2, 3);
    repeat (3) @(negedge clk);
    #1;
    model_eval();
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    idle(4, "R1");

    // R2: every thread empty -> request ignored
    load_rob(6, 0, 2, 0);
    cyc(1'b1, 0, 0, "R2");
    idle(3, "R2");

    // R3 R4 R9: thread 0 full with wrap, boundary 13 -> two groups
    load_rob(6, 8, 2, 3);
    cyc(1'b1, 0, 13, "R3");
    idle(4, "R4");

    // R7: thread 1, boundary 0 -> head reached inside first group
    cyc(1'b1, 1, 0, "R7");
    idle(3, "R7");

    // R5: boundary equal to the youngest, then above it
    cyc(1'b1, 0, 24, "R5");
    idle(3, "R5");
    cyc(1'b1, 0, 30, "R5");
    idle(3, "R5");

    // R8: second group stops on boundary 15 mid-group
    cyc(1'b1, 0, 15, "R8");
    idle(4, "R8");

    // R7: full walk to head over three groups
    cyc(1'b1, 0, 0, "R7");
    idle(5, "R7");

    // R10: restart same thread, then preempt by the other thread
    cyc(1'b1, 0, 0, "R10");
    idle(1, "R10");
    cyc(1'b1, 0, 17, "R10");
    idle(1, "R10");
    cyc(1'b1, 1, 40, "R10");
    idle(3, "R10");

    // R11: empty thread while the other thread holds entries
    load_rob(6, 8, 2, 0);
    cyc(1'b1, 1, 5, "R11");
    idle(3, "R11");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule